// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address of up to 40 bits. It reads the translation tables from memory itself. A request names a virtual address and says whether the access is a write. The walker then reads up to three words over a narrow read port. The first is a root descriptor at a programmable base address. The second is a directory entry, and the third is a page entry. The walker returns either the physical address or a fault. A fault carries a cause code and the virtual address that caused it.

The root descriptor holds the directory base and a page-size mode. The virtual address supplies a 10-bit directory index in bits 31:22, a 10-bit page-table index in bits 21:12 and a 12-bit byte offset in bits 11:0. Each table holds 1024 words and fills one 4 KiB page. The walker keeps the root descriptor and the most recent valid directory entry, so that later walks skip those reads. A flush pulse, or any change of the base address, drops both.

Top module: `tlw_walker`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and both `resp_valid` and `mem_req_valid` are 0.
- R2: On a walk with nothing cached, the block issues three word reads, one after another:
  - the root descriptor at `cfg_base`;
  - the directory entry at `{root[31:10],10'b0} + 4*va[31:22]`;
  - the page entry at `{dir[31:6],6'b0} + 4*va[21:12]`.
- R3: A successful walk gives a one-cycle `resp_valid` pulse with `resp_fault`=0 and `resp_cause`=0. It returns `resp_paddr` = `{pte[11:4], pte[31:12], va[11:0]}` and `resp_vaddr` equal to the request address.
- R4: If directory entry bit 0 is 0, the walk ends with `resp_fault`=1 and `resp_cause`=1, and no page entry is read. On every fault, `resp_paddr` is 0 and `resp_vaddr` holds the request address.
- R5: If page entry bit 0 is 0, the walk ends with cause 2.
- R6: A write request to a valid page entry whose bit 2 is 0 ends with cause 3. A read request to the same entry succeeds.
- R7: If the root mode field (bits 3:0) is not 0, the walk ends with cause 4 and no directory read is made.
- R8: At most one memory read is outstanding at a time. A request is taken only while `req_ready` is 1, and `req_ready` is 0 from the cycle after acceptance until the walk ends.
- R9: Once the root descriptor has been fetched, later walks do not read it again until the cache is invalidated. This also holds when its mode is nonzero; such walks then fault with cause 4 and make no read at all.
- R10: A valid directory entry is kept along with its index. A walk with the same directory index reads only the page entry. A walk with a different index, or one that follows an invalid directory entry, reads the directory entry again.
- R11: A `flush` pulse drops both cached words. A flush during a walk lets that walk finish with its normal result, and the next walk starts again from the root read.
- R12: A change of `cfg_base` invalidates the cached words in the same way as a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 32 | Byte address of the root descriptor |
| flush | input | 1 | One-cycle pulse that drops cached descriptors |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| req_ready | output | 1 | Walker idle, request will be taken |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data word |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_fault | output | 1 | Translation failed |
| resp_cause | output | 3 | 0 ok, 1 directory, 2 page, 3 permission, 4 mode |
| resp_paddr | output | 40 | Physical address, 0 on a fault |
| resp_vaddr | output | 32 | Virtual address of the finished walk |

## Verification
The checks assume that memory answers each read exactly once, no earlier than the cycle after the request. They also assume no response arrives unless a read is pending, and that `cfg_base` only changes between walks. The bench memory model holds each response back a set number of cycles, at least one. It serves one read at a time and changes the base only while the walker is idle. The bench flushes both between walks and in the middle of a walk. The reference model predicts every read address and every result from its own copy of the cache state.

// File: rtl/tlw_pkg.sv
package tlw_pkg;

    localparam int VA_W    = 32;
    localparam int PA_W    = 40;
    localparam int WORD_W  = 32;
    localparam int IDX_W   = 10;
    localparam int OFS_W   = 12;
    localparam int MODE_W  = 4;
    localparam int CAUSE_W = 3;
    localparam int HI_W    = PA_W - VA_W;
    localparam int DIRB_LO = 10;
    localparam int PTB_LO  = 6;

    typedef enum logic [CAUSE_W-1:0] {
        FLT_NONE = 3'd0,
        FLT_DIR  = 3'd1,
        FLT_PAGE = 3'd2,
        FLT_PERM = 3'd3,
        FLT_MODE = 3'd4
    } fault_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_RT_ISS,
        ST_RT_WT,
        ST_DR_ISS,
        ST_DR_WT,
        ST_PT_ISS,
        ST_PT_WT,
        ST_FIN
    } walk_st_e;

    typedef struct packed {
        logic [VA_W-1:0] vaddr;
        logic            wr;
    } walk_req_t;

    function automatic logic [IDX_W-1:0] dir_idx(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] pt_idx(input logic [VA_W-1:0] va);
        return va[OFS_W +: IDX_W];
    endfunction

    function automatic logic [MODE_W-1:0] root_mode(input logic [WORD_W-1:0] r);
        return r[MODE_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] root_dir_base(input logic [WORD_W-1:0] r);
        return {r[WORD_W-1:DIRB_LO], {DIRB_LO{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] dte_pt_base(input logic [WORD_W-1:0] d);
        return {d[WORD_W-1:PTB_LO], {PTB_LO{1'b0}}};
    endfunction

    function automatic logic ent_valid(input logic [WORD_W-1:0] e);
        return e[0];
    endfunction

    function automatic logic pte_writable(input logic [WORD_W-1:0] e);
        return e[2];
    endfunction

    function automatic logic [WORD_W-1:0] entry_addr(input logic [WORD_W-1:0] base,
                                                     input logic [IDX_W-1:0]  idx);
        return base + {{(WORD_W-IDX_W-2){1'b0}}, idx, 2'b00};
    endfunction

    function automatic logic [PA_W-1:0] pte_paddr(input logic [WORD_W-1:0] e,
                                                  input logic [VA_W-1:0]   va);
        return {e[4 +: HI_W], e[WORD_W-1:OFS_W], va[OFS_W-1:0]};
    endfunction

endpackage

// File: rtl/tlw_base_watch.sv
module tlw_base_watch
    import tlw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] cfg_base,
    input  logic              flush,
    output logic              inval
);
    logic [WORD_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) base_q <= '0;
        else     base_q <= cfg_base;
    end

    // R12: a new base behaves as a flush
    assign inval = flush || (cfg_base != base_q);

endmodule

// File: rtl/tlw_desc_cache.sv
module tlw_desc_cache
    import tlw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inval,
    input  logic              root_fill,
    input  logic              dir_fill,
    input  logic [WORD_W-1:0] fill_data,
    input  logic [IDX_W-1:0]  fill_idx,
    output logic              root_valid,
    output logic [WORD_W-1:0] root_q,
    output logic              dir_valid,
    output logic [IDX_W-1:0]  dir_tag,
    output logic [WORD_W-1:0] dir_q
);
    always_ff @(posedge clk) begin
        if (rst || inval) begin
            root_valid <= 1'b0;
            dir_valid  <= 1'b0;
        end else begin
            if (root_fill) root_valid <= 1'b1;
            if (dir_fill)  dir_valid  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            root_q  <= '0;
            dir_q   <= '0;
            dir_tag <= '0;
        end else begin
            if (root_fill) root_q <= fill_data;
            if (dir_fill) begin
                dir_q   <= fill_data;
                dir_tag <= fill_idx;
            end
        end
    end

    a_r11_inval_clears: assert property (@(posedge clk) disable iff (rst)
        inval |=> (!root_valid && !dir_valid));

    a_r10_dir_needs_root: assert property (@(posedge clk) disable iff (rst)
        dir_valid |-> root_valid);

endmodule

// File: rtl/tlw_walk_ctrl.sv
module tlw_walk_ctrl
    import tlw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  walk_req_t          req,
    output logic               req_ready,
    input  logic               inval,
    input  logic [WORD_W-1:0]  cfg_base,
    input  logic               root_valid,
    input  logic [WORD_W-1:0]  root_q,
    input  logic               dir_valid,
    input  logic [IDX_W-1:0]   dir_tag,
    input  logic [WORD_W-1:0]  dir_q,
    output logic               root_fill,
    output logic               dir_fill,
    output logic [WORD_W-1:0]  fill_data,
    output logic [IDX_W-1:0]   fill_idx,
    output logic               mem_req_valid,
    output logic [WORD_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [WORD_W-1:0]  mem_rsp_data,
    output logic               resp_valid,
    output logic               resp_fault,
    output logic [CAUSE_W-1:0] resp_cause,
    output logic [PA_W-1:0]    resp_paddr,
    output logic [VA_W-1:0]    resp_vaddr
);
    walk_st_e          state, state_n;
    walk_req_t         cur_q;
    fault_e            cause_q, cause_n;
    logic [PA_W-1:0]   paddr_q, paddr_n;
    logic [WORD_W-1:0] root_w, root_n;
    logic [WORD_W-1:0] dte_w, dte_n;
    logic              stale_q;
    logic              may_fill;
    logic              accept;

    assign accept   = (state == ST_IDLE) && req_valid;
    assign may_fill = !stale_q && !inval;

    always_comb begin
        state_n       = state;
        cause_n       = cause_q;
        paddr_n       = paddr_q;
        root_n        = root_w;
        dte_n         = dte_w;
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        root_fill     = 1'b0;
        dir_fill      = 1'b0;
        fill_data     = mem_rsp_data;
        fill_idx      = dir_idx(cur_q.vaddr);
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_n = ST_DECIDE;
                    cause_n = FLT_NONE;
                    paddr_n = '0;
                end
            end
            ST_DECIDE: begin
                if (!root_valid) begin
                    state_n = ST_RT_ISS;
                end else begin
                    root_n = root_q;
                    if (root_mode(root_q) != '0) begin
                        cause_n = FLT_MODE;
                        state_n = ST_FIN;
                    end else if (dir_valid && dir_tag == dir_idx(cur_q.vaddr)) begin
                        dte_n   = dir_q;
                        state_n = ST_PT_ISS;
                    end else begin
                        state_n = ST_DR_ISS;
                    end
                end
            end
            ST_RT_ISS: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = cfg_base;
                state_n       = ST_RT_WT;
            end
            ST_RT_WT: begin
                if (mem_rsp_valid) begin
                    root_n    = mem_rsp_data;
                    root_fill = may_fill;
                    if (root_mode(mem_rsp_data) != '0) begin
                        cause_n = FLT_MODE;
                        state_n = ST_FIN;
                    end else begin
                        state_n = ST_DR_ISS;
                    end
                end
            end
            ST_DR_ISS: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = entry_addr(root_dir_base(root_w), dir_idx(cur_q.vaddr));
                state_n       = ST_DR_WT;
            end
            ST_DR_WT: begin
                if (mem_rsp_valid) begin
                    dte_n = mem_rsp_data;
                    if (!ent_valid(mem_rsp_data)) begin
                        cause_n = FLT_DIR;
                        state_n = ST_FIN;
                    end else begin
                        dir_fill = may_fill;
                        state_n  = ST_PT_ISS;
                    end
                end
            end
            ST_PT_ISS: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = entry_addr(dte_pt_base(dte_w), pt_idx(cur_q.vaddr));
                state_n       = ST_PT_WT;
            end
            ST_PT_WT: begin
                if (mem_rsp_valid) begin
                    state_n = ST_FIN;
                    if (!ent_valid(mem_rsp_data))
                        cause_n = FLT_PAGE;
                    else if (cur_q.wr && !pte_writable(mem_rsp_data))
                        cause_n = FLT_PERM;
                    else
                        paddr_n = pte_paddr(mem_rsp_data, cur_q.vaddr);
                end
            end
            ST_FIN:  state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur_q   <= '0;
            cause_q <= FLT_NONE;
            paddr_q <= '0;
            root_w  <= '0;
            dte_w   <= '0;
            stale_q <= 1'b0;
        end else begin
            state   <= state_n;
            cause_q <= cause_n;
            paddr_q <= paddr_n;
            root_w  <= root_n;
            dte_w   <= dte_n;
            if (accept) begin
                cur_q   <= req;
                stale_q <= inval;
            end else if (inval) begin
                stale_q <= 1'b1;
            end
        end
    end

    assign req_ready  = (state == ST_IDLE);
    assign resp_valid = (state == ST_FIN);
    assign resp_cause = cause_q;
    assign resp_fault = (cause_q != FLT_NONE);
    assign resp_paddr = paddr_q;
    assign resp_vaddr = cur_q.vaddr;

    a_r3_resp_pulse: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    a_r4_fault_paddr_zero: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |-> (resp_paddr == '0));

    a_r7_no_dir_on_mode: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DR_ISS) |-> (root_mode(root_w) == '0));

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

endmodule

// File: rtl/tlw_walker.sv
module tlw_walker
    import tlw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [WORD_W-1:0]  cfg_base,
    input  logic               flush,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    output logic               req_ready,
    output logic               mem_req_valid,
    output logic [WORD_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [WORD_W-1:0]  mem_rsp_data,
    output logic               resp_valid,
    output logic               resp_fault,
    output logic [CAUSE_W-1:0] resp_cause,
    output logic [PA_W-1:0]    resp_paddr,
    output logic [VA_W-1:0]    resp_vaddr
);
    logic              inval;
    logic              root_valid, dir_valid;
    logic [WORD_W-1:0] root_q, dir_q, fill_data;
    logic [IDX_W-1:0]  dir_tag, fill_idx;
    logic              root_fill, dir_fill;
    walk_req_t         req_s;

    assign req_s = '{vaddr: req_vaddr, wr: req_write};

    tlw_base_watch u_watch (
        .clk      (clk),
        .rst      (rst),
        .cfg_base (cfg_base),
        .flush    (flush),
        .inval    (inval)
    );

    tlw_desc_cache u_cache (
        .clk        (clk),
        .rst        (rst),
        .inval      (inval),
        .root_fill  (root_fill),
        .dir_fill   (dir_fill),
        .fill_data  (fill_data),
        .fill_idx   (fill_idx),
        .root_valid (root_valid),
        .root_q     (root_q),
        .dir_valid  (dir_valid),
        .dir_tag    (dir_tag),
        .dir_q      (dir_q)
    );

    tlw_walk_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req           (req_s),
        .req_ready     (req_ready),
        .inval         (inval),
        .cfg_base      (cfg_base),
        .root_valid    (root_valid),
        .root_q        (root_q),
        .dir_valid     (dir_valid),
        .dir_tag       (dir_tag),
        .dir_q         (dir_q),
        .root_fill     (root_fill),
        .dir_fill      (dir_fill),
        .fill_data     (fill_data),
        .fill_idx      (fill_idx),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .resp_valid    (resp_valid),
        .resp_fault    (resp_fault),
        .resp_cause    (resp_cause),
        .resp_paddr    (resp_paddr),
        .resp_vaddr    (resp_vaddr)
    );

    // outstanding-read tracker for the port-level checks
    logic rd_pending;
    always_ff @(posedge clk) begin
        if (rst)                rd_pending <= 1'b0;
        else if (mem_req_valid) rd_pending <= 1'b1;
        else if (mem_rsp_valid) rd_pending <= 1'b0;
    end

    a_r8_one_read: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !rd_pending);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid);

    a_r4_fault_flag: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_fault == (resp_cause != '0)));

endmodule

// File: tb/tlw_walker_tb_top.sv
module tlw_walker_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cfg_base;
    logic        flush;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        req_write;
    logic        req_ready;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        resp_valid;
    logic        resp_fault;
    logic [2:0]  resp_cause;
    logic [39:0] resp_paddr;
    logic [31:0] resp_vaddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlw_walker dut_i (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .flush(flush),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .req_ready(req_ready), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .resp_valid(resp_valid),
        .resp_fault(resp_fault), .resp_cause(resp_cause),
        .resp_paddr(resp_paddr), .resp_vaddr(resp_vaddr)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] expq [$];
    int          lat = 1;
    bit          pend = 0;
    int          cnt = 0;
    logic [31:0] pend_addr;

    // reference cache state
    bit          m_rv = 0, m_dv = 0, m_busy = 0, m_stale = 0;
    logic [31:0] m_root, m_dte;
    logic [9:0]  m_didx;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // memory responder and read-address monitor, every clock
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (cnt <= 1) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(pend_addr);
                pend = 0;
            end else cnt--;
        end
        if (mem_req_valid) begin
            if (expq.size() == 0)
                chk(0, "R2", "unexpected read", {32'h0, mem_req_addr}, 64'h0);
            else begin
                logic [31:0] e;
                e = expq.pop_front();
                chk(mem_req_addr == e, "R2", "read address", {32'h0, mem_req_addr}, {32'h0, e});
            end
            chk(!pend, "R8", "second outstanding read", 64'(pend), 64'h0);
            pend = 1; cnt = lat; pend_addr = mem_req_addr;
        end
    end

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        m_rv = 0; m_dv = 0;
        if (m_busy) m_stale = 1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        cfg_base = b;
        m_rv = 0; m_dv = 0;
        @(negedge clk);
    endtask

    task automatic translate(input logic [31:0] va, input bit wr, input string rq);
        logic [31:0] root, dte, pte;
        logic [2:0]  ecause;
        logic [39:0] epa;
        bit          got_root, got_dir;
        int          n;
        got_root = 0; got_dir = 0; ecause = 0; epa = 0; dte = 0;
        expq.delete();
        if (m_rv) root = m_root;
        else begin
            expq.push_back(cfg_base); root = rd(cfg_base); got_root = 1;
        end
        if (root[3:0] != 0) ecause = 4;
        else begin
            if (m_dv && m_didx == va[31:22]) dte = m_dte;
            else begin
                logic [31:0] a;
                a = {root[31:10], 10'h0} + {20'h0, va[31:22], 2'b00};
                expq.push_back(a); dte = rd(a); got_dir = 1;
            end
            if (!dte[0]) ecause = 1;
            else begin
                logic [31:0] a;
                a = {dte[31:6], 6'h0} + {20'h0, va[21:12], 2'b00};
                expq.push_back(a); pte = rd(a);
                if (!pte[0])             ecause = 2;
                else if (wr && !pte[2])  ecause = 3;
                else epa = {pte[11:4], pte[31:12], va[11:0]};
            end
        end
        m_busy = 1; m_stale = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8", "ready while busy", 64'(req_ready), 64'h0);
        n = 0;
        while (!resp_valid && n < 500) begin @(negedge clk); n++; end
        chk(resp_valid, rq, "response timeout", 64'(resp_valid), 64'h1);
        chk(resp_cause == ecause, rq, "cause", 64'(resp_cause), 64'(ecause));
        chk(resp_fault == (ecause != 0), rq, "fault flag", 64'(resp_fault), 64'(ecause != 0));
        chk(resp_paddr == epa, rq, "paddr", 64'(resp_paddr), 64'(epa));
        chk(resp_vaddr == va, rq, "vaddr", 64'(resp_vaddr), 64'(va));
        chk(expq.size() == 0, rq, "reads missing", 64'(expq.size()), 64'h0);
        @(negedge clk);
        chk(!resp_valid, "R3", "response pulse width", 64'(resp_valid), 64'h0);
        m_busy = 0;
        if (!m_stale) begin
            if (got_root) begin m_rv = 1; m_root = root; end
            if (got_dir && dte[0]) begin m_dv = 1; m_didx = va[31:22]; m_dte = dte; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; flush = 0; req_valid = 0; req_vaddr = 0; req_write = 0;
        cfg_base = 32'h1000; mem_rsp_valid = 0; mem_rsp_data = 0;
        // tables behind base A
        mem[32'h0000_1000] = 32'h0010_0000;
        mem[32'h0010_0004] = 32'h0020_0041;
        mem[32'h0020_004C] = 32'hABCD_E5A5;
        mem[32'h0020_0050] = 32'h1234_5001;
        mem[32'h0010_000C] = 32'h0030_0001;
        mem[32'h0030_001C] = 32'hFFFF_FFF5;
        // base B: nonzero mode
        mem[32'h0000_2000] = 32'h0010_0003;
        // base C
        mem[32'h0000_3000] = 32'h0040_0000;
        mem[32'h0040_0004] = 32'h0050_0001;
        mem[32'h0050_000C] = 32'h0004_2011;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1, "R1", "reset ready", 64'(req_ready), 64'h1);
        chk(resp_valid == 0, "R1", "reset resp_valid", 64'(resp_valid), 64'h0);
        chk(mem_req_valid == 0, "R1", "reset mem_req_valid", 64'(mem_req_valid), 64'h0);

        translate(32'h0040_3123, 0, "R2");  // full walk
        chk(resp_paddr == 40'h5A_ABCD_E123, "R3", "packed high bits", 64'(resp_paddr), 64'h5AABCDE123);
        translate(32'h0040_3123, 1, "R9");  // root and dir cached
        translate(32'h0040_4ABC, 0, "R6");  // read of read-only page
        translate(32'h0040_4ABC, 1, "R6");  // write of read-only page
        translate(32'h0040_5000, 0, "R5");  // invalid page entry
        lat = 3;
        translate(32'h0080_0010, 1, "R4");  // invalid directory entry
        translate(32'h0080_0010, 0, "R10"); // invalid dte not kept
        translate(32'h00C0_7FFF, 0, "R3");  // all-ones physical address
        translate(32'h0040_3000, 0, "R10"); // other index: dir refetch
        pulse_flush();
        translate(32'h0040_3123, 0, "R11"); // refetch after flush
        fork
            translate(32'h00C0_7FFF, 1, "R11");
            begin repeat (5) @(negedge clk); pulse_flush(); end
        join
        translate(32'h00C0_7FFF, 0, "R11"); // starts from root again
        lat = 1;
        set_base(32'h2000);
        translate(32'h0040_3123, 0, "R7");  // mode fault, one read
        translate(32'h0040_3123, 0, "R9");  // mode fault, no reads
        set_base(32'h3000);
        translate(32'h0040_3123, 0, "R12"); // new tables used
        chk(resp_paddr == 40'h01_0004_2123, "R12", "paddr new base", 64'(resp_paddr), 64'h0100042123);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule